// File: doc/BRIEF.md
# Double-Buffered Three-Axis Corner Turner

This block reorders a stream of channelized samples so that a downstream correlation engine receives every time sample of one channel and signal back to back. Words enter with the time index outermost, the channel index in the middle and the signal index innermost. In effect, each time step delivers one channel-by-signal matrix, row by row. Words leave with the channel index outermost, then the signal index, and the time index innermost. Each reorder block covers `TSAMP` time samples, which is one integration length.

Storage holds two complete blocks. One bank fills with the integration that is arriving while the other bank is read out in transposed order. The banks exchange roles only when two conditions hold together: the write side has completed its block and the read side has drained the previous one. The exchange takes one clock cycle.

Both data paths use valid/ready handshakes. A word moves on a clock edge where valid and ready are both high. The input side drops `in_ready` while its bank is full and waiting for the exchange. The output side holds its word and flags steady for as long as `out_ready` stays low, and it never withdraws `out_valid` before the handshake.

Top module: `cube_turner`

## Requirements
- R1: The input word accepted as the k-th word of a block, with k = t·CHANS·SIGS + c·SIGS + s, is stored as element (time t, channel c, signal s).
- R2: Within a block, output words leave in the order channel, then signal, then time, with time innermost. The j-th output word of a block is element (c = j / (SIGS·TSAMP), s = (j / TSAMP) mod SIGS, t = j mod TSAMP).
- R3: The next block can be accepted while the previous block is still being read out, so input and output transfers overlap in time.
- R4: When one block is waiting to be read and a second block has filled, `in_ready` stays low. At most 2·CHANS·SIGS·TSAMP words are ever held. A word is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R5: Every block emits exactly CHANS·SIGS·TSAMP words. `out_first` is high on the first of these words and `out_last` is high on the final one.
- R6: After reset `in_ready` is 1 and `out_valid` is 0. No output word appears until one complete block has been accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | DW | Input sample word, time-major order |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | DW | Output sample word, channel-major order |
| out_first | output | 1 | Marks the first word of a block |
| out_last | output | 1 | Marks the final word of a block |

## Verification
The bench builds the block with CHANS=3, SIGS=2 and TSAMP=4. Because these three sizes differ, any swap of two index axes or any wrong stride produces a different word sequence. Each input word carries its own global index, so the bench can compute the expected transposed value for every output word of six consecutive blocks by arithmetic. One phase blocks the consumer entirely to fill both banks and reach the stall. Another phase applies gapped valid and gapped ready patterns, which exercise the bank exchange in both orders: a write that finishes first and a drain that finishes first.

// File: rtl/cube_turner_pkg.sv
package cube_turner_pkg;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [0:0] {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_t;

endpackage

// File: rtl/cube_wr_seq.sv
module cube_wr_seq
  import cube_turner_pkg::*;
#(
  parameter int CHANS = 3,
  parameter int SIGS  = 2,
  parameter int TSAMP = 4,
  localparam int BLK  = CHANS * SIGS * TSAMP,
  localparam int AW   = cnt_width(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam int CW = cnt_width(CHANS);
  localparam int SW = cnt_width(SIGS);
  localparam int TW = cnt_width(TSAMP);

  logic [CW-1:0] c_q;
  logic [SW-1:0] s_q;
  logic [TW-1:0] t_q;
  logic s_wrap, c_wrap, t_wrap;

  assign s_wrap = (int'(s_q) == SIGS - 1);
  assign c_wrap = (int'(c_q) == CHANS - 1);
  assign t_wrap = (int'(t_q) == TSAMP - 1);
  assign at_end = s_wrap && c_wrap && t_wrap;

  // time outermost, signal innermost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= '0;
      s_q <= '0;
      t_q <= '0;
    end else if (adv) begin
      if (s_wrap) begin
        s_q <= '0;
        if (c_wrap) begin
          c_q <= '0;
          t_q <= t_wrap ? '0 : t_q + 1'b1;
        end else begin
          c_q <= c_q + 1'b1;
        end
      end else begin
        s_q <= s_q + 1'b1;
      end
    end
  end

  assign addr = AW'(int'(t_q) * CHANS * SIGS + int'(c_q) * SIGS + int'(s_q));

endmodule

// File: rtl/cube_rd_seq.sv
module cube_rd_seq
  import cube_turner_pkg::*;
#(
  parameter int CHANS = 3,
  parameter int SIGS  = 2,
  parameter int TSAMP = 4,
  localparam int BLK  = CHANS * SIGS * TSAMP,
  localparam int AW   = cnt_width(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          at_start,
  output logic          at_end
);
  localparam int CW = cnt_width(CHANS);
  localparam int SW = cnt_width(SIGS);
  localparam int TW = cnt_width(TSAMP);

  logic [CW-1:0] c_q;
  logic [SW-1:0] s_q;
  logic [TW-1:0] t_q;
  logic t_wrap, s_wrap, c_wrap;

  assign t_wrap   = (int'(t_q) == TSAMP - 1);
  assign s_wrap   = (int'(s_q) == SIGS - 1);
  assign c_wrap   = (int'(c_q) == CHANS - 1);
  assign at_end   = t_wrap && s_wrap && c_wrap;
  assign at_start = (c_q == '0) && (s_q == '0) && (t_q == '0);

  // channel outermost, time innermost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= '0;
      s_q <= '0;
      t_q <= '0;
    end else if (adv) begin
      if (t_wrap) begin
        t_q <= '0;
        if (s_wrap) begin
          s_q <= '0;
          c_q <= c_wrap ? '0 : c_q + 1'b1;
        end else begin
          s_q <= s_q + 1'b1;
        end
      end else begin
        t_q <= t_q + 1'b1;
      end
    end
  end

  assign addr = AW'(int'(t_q) * CHANS * SIGS + int'(c_q) * SIGS + int'(s_q));

endmodule

// File: rtl/cube_bank_mem.sv
module cube_bank_mem
  import cube_turner_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 24,
  localparam int AW   = cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  bank_t         wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  bank_t         rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (int'(wbank) == b)) store[waddr] <= wdata;
    end

    assign rd_word[b] = store[raddr];
  end

  assign rdata = rd_word[int'(rbank)];

endmodule

// File: rtl/cube_swap_ctl.sv
module cube_swap_ctl
  import cube_turner_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_done,
  input  logic  rd_done,
  output bank_t wr_bank,
  output bank_t rd_bank,
  output logic  wr_full,
  output logic  rd_busy
);
  logic swap;

  assign swap = wr_full && !rd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= BANK_A;
      rd_bank <= BANK_B;
      wr_full <= 1'b0;
      rd_busy <= 1'b0;
    end else if (swap) begin
      rd_bank <= wr_bank;
      wr_bank <= (wr_bank == BANK_A) ? BANK_B : BANK_A;
      wr_full <= 1'b0;
      rd_busy <= 1'b1;
    end else begin
      if (wr_done) wr_full <= 1'b1;
      if (rd_done) rd_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/cube_turner.sv
module cube_turner
  import cube_turner_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CHANS = 3,
  parameter int SIGS  = 2,
  parameter int TSAMP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_first,
  output logic          out_last
);
  localparam int BLK = CHANS * SIGS * TSAMP;
  localparam int AW  = cnt_width(BLK);

  logic          in_hs, out_hs;
  logic [AW-1:0] waddr, raddr;
  logic          w_end, r_end, r_start;
  bank_t         wr_bank, rd_bank;
  logic          wr_full, rd_busy;

  assign in_ready  = !wr_full;
  assign in_hs     = in_valid && in_ready;
  assign out_valid = rd_busy;
  assign out_hs    = out_valid && out_ready;

  cube_wr_seq #(.CHANS(CHANS), .SIGS(SIGS), .TSAMP(TSAMP)) wr_i (
    .clk(clk), .rst_n(rst_n), .adv(in_hs), .addr(waddr), .at_end(w_end)
  );

  cube_rd_seq #(.CHANS(CHANS), .SIGS(SIGS), .TSAMP(TSAMP)) rd_i (
    .clk(clk), .rst_n(rst_n), .adv(out_hs), .addr(raddr),
    .at_start(r_start), .at_end(r_end)
  );

  cube_swap_ctl ctl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_done(in_hs && w_end), .rd_done(out_hs && r_end),
    .wr_bank(wr_bank), .rd_bank(rd_bank),
    .wr_full(wr_full), .rd_busy(rd_busy)
  );

  cube_bank_mem #(.DW(DW), .DEPTH(BLK)) mem_i (
    .clk(clk), .we(in_hs), .wbank(wr_bank), .waddr(waddr), .wdata(in_data),
    .rbank(rd_bank), .raddr(raddr), .rdata(out_data)
  );

  assign out_first = rd_busy && r_start;
  assign out_last  = rd_busy && r_end;

endmodule

// File: rtl/cube_turner_chk.sv
module cube_turner_chk #(
  parameter int DW    = 16,
  parameter int CHANS = 3,
  parameter int SIGS  = 2,
  parameter int TSAMP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_first,
  input logic          out_last
);
  localparam int BLK = CHANS * SIGS * TSAMP;

  int  occ;
  int  in_cnt;
  int  out_pos;
  logic seen_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ       <= 0;
      in_cnt    <= 0;
      out_pos   <= 0;
      seen_full <= 1'b0;
    end else begin
      occ <= occ + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
      if (in_valid && in_ready && in_cnt < BLK) in_cnt <= in_cnt + 1;
      if (in_valid && in_ready && in_cnt == BLK - 1) seen_full <= 1'b1;
      if (out_valid && out_ready) out_pos <= (out_pos == BLK - 1) ? 0 : out_pos + 1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 2 * BLK && (in_ready -> occ < 2 * BLK));

  assert_no_early_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_full);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_first) && $stable(out_last));

  assert_first_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == (out_pos == 0)));

  assert_last_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (out_pos == BLK - 1)));

endmodule

bind cube_turner cube_turner_chk #(
  .DW(DW), .CHANS(CHANS), .SIGS(SIGS), .TSAMP(TSAMP)
) chk_i (.*);

// File: tb/cube_turner_tb_top.sv
module cube_turner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int CHANS = 3;
  localparam int SIGS  = 2;
  localparam int TSAMP = 4;
  localparam int BLK   = CHANS * SIGS * TSAMP;
  localparam int NBLK  = 6;
  localparam int TOTAL = NBLK * BLK;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic out_first, out_last;

  int errors = 0;
  int checks = 0;
  int in_idx = 0;
  int out_idx = 0;
  int cyc = 0;
  int overlap = 0;
  bit hung = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cube_turner #(.DW(DW), .CHANS(CHANS), .SIGS(SIGS), .TSAMP(TSAMP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected value of the idx-th output word overall
  function automatic int exp_word(input int idx);
    int blk = idx / BLK;
    int p   = idx % BLK;
    int c   = p / (SIGS * TSAMP);
    int s   = (p / TSAMP) % SIGS;
    int t   = p % TSAMP;
    return blk * BLK + t * CHANS * SIGS + c * SIGS + s;
  endfunction

  // one negedge step: drive, then record handshakes that will occur at next posedge
  task automatic step(input bit want_in, input bit want_out);
    @(negedge clk);
    cyc++;
    in_valid  = want_in && (in_idx < TOTAL);
    in_data   = DW'(in_idx);
    out_ready = want_out;
    #1;
    if (out_valid) begin
      chk("R2 out_data order", int'(out_data), exp_word(out_idx));
      chk("R5 out_first", int'(out_first), int'((out_idx % BLK) == 0));
      chk("R5 out_last", int'(out_last), int'((out_idx % BLK) == BLK - 1));
      if (out_ready) begin
        if (in_valid && in_ready) overlap++;
        out_idx++;
      end
    end
    if (in_valid && in_ready) in_idx++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 reset in_ready", int'(in_ready), 1);
    chk("R6 reset out_valid", int'(out_valid), 0);

    // phase B: consumer blocked, fill both banks
    for (int i = 0; i < 80; i++) begin
      if (in_idx < BLK) chk("R6 no early output", int'(out_valid), 0);
      step(1'b1, 1'b0);
    end
    chk("R4 accepted words with stalled reader", in_idx, 2 * BLK);
    chk("R4 in_ready low when both banks full", int'(in_ready), 0);
    chk("R7 out_valid held", int'(out_valid), 1);
    chk("R7 out_data held", int'(out_data), 0);
    chk("R5 first flag held", int'(out_first), 1);

    // phase C: gapped patterns, then free running
    while (out_idx < TOTAL && !hung) begin
      if (out_idx < 3 * BLK)
        step((cyc % 5) != 3, (cyc % 7) < 4);
      else
        step(1'b1, (cyc % 3) != 0);
      if (cyc > WATCHDOG) hung = 1;
    end
    if (hung) chk("watchdog", out_idx, TOTAL);

    chk("R1 all input words taken", in_idx, TOTAL);
    chk("R3 input overlaps output", int'(overlap > 0), 1);
    repeat (3) step(1'b0, 1'b1);
    chk("R6 idle out_valid", int'(out_valid), 0);
    chk("R4 idle in_ready", int'(in_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule